// File: doc/BRIEF.md
# Serial Receiver with Error Status

This block is the receive half of an asynchronous serial port. It watches a serial input line, spots the falling edge of a start bit, confirms it at the middle of the bit and then takes each data bit at the centre of its bit period. All timing comes from an external tick at sixteen times the bit rate. An optional parity bit, either even or odd, comes after the data bits, and a stop bit ends the frame. Each byte received lands in a one-entry receive buffer.

Software reaches the block over a small register bus. One address returns the received byte, and reading it marks the buffer empty. A second address returns an 8-bit status register that holds three sticky-style error indications: framing, overrun and parity. Any write to the status address clears all three at once. Turning the receiver off aborts a frame in progress but leaves the buffer and its unread state alone. A byte left unread across an off/on cycle therefore still causes an overrun on the next frame.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the status register (address 1) reads 0x00.
- R2: A frame carries 8 data bits, least significant bit first. Its byte is readable at address 0 once the frame has completed.
- R3: Status bit 0 is the framing flag, bit 1 the overrun flag and bit 2 the parity flag. Bits 7 to 3 always read 0.
- R4: A write to address 1 with any data value clears all three status flags.
- R5: A stop bit sampled low sets the framing flag when the frame completes.
- R6: A start bit that is high again at its mid-bit check does not abort the frame. The frame runs to completion and sets the framing flag.
- R7: The framing flag is recomputed on every completed frame, so a clean frame clears it.
- R8: With parity enabled, the parity bit is the XOR of the data bits, inverted when odd parity is selected. A mismatch sets the parity flag, and the flag is recomputed on every completed frame.
- R9: A frame that completes while the buffer holds an unread byte sets the overrun flag. The new byte replaces the old one.
- R10: A read of address 0 empties the buffer, so the next frame does not set the overrun flag.
- R11: The overrun flag stays set across later clean frames until a status write clears it.
- R12: While reception is disabled, line activity neither completes a frame nor changes any flag. An unread byte left from before the disable still causes an overrun on the first frame after re-enabling.
- R13: When a frame completes in the same cycle as a status write, the frame's flag results take effect and the write does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| addr | input | 2 | Register address: 0 receive buffer, 1 status |
| rd | input | 1 | Read strobe; a read at address 0 empties the buffer |
| wr | input | 1 | Write strobe; a write at address 1 clears the flags |
| wdata | input | 8 | Write data (value is ignored) |
| rdata | output | 8 | Read data for the addressed register, combinational |

## Verification
The serial line passes through two synchronizer flops. The frame result is registered at the tick that samples the middle of the stop bit, and the buffer and flags update one clock after that. All results are therefore ready about half a bit period before the stop bit ends. The bench always sends the complete frame and then idles for more than a quarter bit before it reads any register. Read data is combinational, so it is sampled shortly after the falling edge while the strobe is held. The only result that must be seen in an exact cycle is the same-cycle priority case. For that case the bench holds the status write active throughout a frame and samples the status on every cycle. It expects the framing flag to be visible in the one cycle between the frame completing and the next write clearing it.

// File: rtl/uart_rx_pkg.sv
// Package: shared constants and types for the serial receiver.
// Assumes an 8-bit register bus with a two-bit address space.
package uart_rx_pkg;

    // Register addresses decoded by the register block
    localparam int unsigned ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] A_BUF  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;

    // Status bit positions as seen by software
    localparam int unsigned ST_FRAME = 0;
    localparam int unsigned ST_OVER  = 1;
    localparam int unsigned ST_PAR   = 2;
    localparam int unsigned ST_FLAGS = 3;

    // Receive frame sequencer states
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_t;

    // Result handed from the frame sequencer to the register block
    typedef struct packed {
        logic [7:0] data;
        logic       fer;
        logic       per;
    } rx_result_t;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. Assumes STAGES >= 2; resets to the idle (high) level.
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
// Module: rx_frame
// Frame sequencer. On a high-to-low transition of the synchronized line,
// observed at a baud tick, it counts to mid-start, records whether the
// start bit was still low, then samples DATA_W data bits (LSB first), an
// optional parity bit and the stop bit, each at OSR ticks spacing.
// A one-cycle done pulse carries the byte and the error results.
// Assumes baud_tick is a single-cycle pulse at OSR times the bit rate.
// Deasserting en aborts any frame in progress.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  logic        rxs,
    input  logic        par_en,
    input  logic        par_odd,
    output logic        done,
    output rx_result_t  res
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [DATA_W-1:0]  shreg;
    logic               prev_lvl;
    logic               start_bad;
    logic               par_bit;
    logic               par_en_q;
    logic               par_odd_q;
    logic               edge_seen;
    logic               at_mid;
    logic               at_last;
    logic               par_exp;

    // Decode of the current tick position and the start edge
    always_comb begin
        edge_seen = prev_lvl && !rxs;
        at_mid    = (cnt == CNT_MID);
        at_last   = (cnt == CNT_LAST);
        par_exp   = (^shreg) ^ par_odd_q;
    end

    // Line level at the previous tick, used for start-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b1;
        end else if (tick) begin
            prev_lvl <= rxs;
        end
    end

    // Frame sequencer: start check, data shift, parity and stop sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            start_bad <= 1'b0;
            par_bit   <= 1'b0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
            done      <= 1'b0;
            res       <= '0;
        end else if (!en) begin
            state <= RX_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (edge_seen) begin
                            state     <= RX_START;
                            cnt       <= '0;
                            par_en_q  <= par_en;
                            par_odd_q <= par_odd;
                        end
                    end
                    RX_START: begin
                        if (at_mid) begin
                            start_bad <= rxs;
                            cnt       <= '0;
                            bitn      <= '0;
                            state     <= RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_last) begin
                            shreg <= {rxs, shreg[DATA_W-1:1]};
                            cnt   <= '0;
                            if (bitn == BIT_LAST) begin
                                state <= par_en_q ? RX_PAR : RX_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (at_last) begin
                            par_bit <= rxs;
                            cnt     <= '0;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_last) begin
                            done     <= 1'b1;
                            res.data <= shreg;
                            res.fer  <= start_bad || !rxs;
                            res.per  <= par_en_q && (par_bit != par_exp);
                            cnt      <= '0;
                            state    <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_regs.sv
// Module: rx_regs
// Software-visible state: the one-entry receive buffer with its full
// marker and the three error flags. A completed frame has priority over
// a same-cycle status write or buffer read. Read data is combinational.
// Assumes done is a single-cycle pulse from the frame sequencer.
module rx_regs
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  rx_result_t           res,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    output logic [DATA_W-1:0]    rdata,
    output logic                 full,
    output logic [ST_FLAGS-1:0]  flags
);

    logic [DATA_W-1:0] buf_q;
    logic              stat_wr;
    logic              buf_rd;

    // Bus strobe decode
    always_comb begin
        stat_wr = wr && (addr == A_STAT);
        buf_rd  = rd && (addr == A_BUF);
    end

    // Receive buffer contents, overwritten by every completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (done) begin
            buf_q <= res.data;
        end
    end

    // Buffer-full marker: set by a frame, cleared by a buffer read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (done) begin
            full <= 1'b1;
        end else if (buf_rd) begin
            full <= 1'b0;
        end
    end

    // Framing and parity flags follow each frame; a status write clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags[ST_FRAME] <= 1'b0;
            flags[ST_PAR]   <= 1'b0;
        end else if (done) begin
            flags[ST_FRAME] <= res.fer;
            flags[ST_PAR]   <= res.per;
        end else if (stat_wr) begin
            flags[ST_FRAME] <= 1'b0;
            flags[ST_PAR]   <= 1'b0;
        end
    end

    // Overrun flag: set on a frame into a full buffer, cleared only by a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags[ST_OVER] <= 1'b0;
        end else if (done && full) begin
            flags[ST_OVER] <= 1'b1;
        end else if (stat_wr && !done) begin
            flags[ST_OVER] <= 1'b0;
        end
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_BUF:   rdata = buf_q;
            A_STAT:  rdata = DATA_W'(flags);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_rx_stat.sv
// Module: uart_rx_stat
// Top of the serial receiver: line synchronizer, frame sequencer and the
// register block. Assumes an external 16x baud tick and a synchronous
// active-low reset; the write data value is not used.
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic                rxs;
    logic                frm_done;
    rx_result_t          frm_res;
    logic                frm_fer;
    logic                frm_per;
    logic                buf_full;
    logic [ST_FLAGS-1:0] stat_flags;
    logic                wdata_unused;

    // The status register clears on any write; its data is not used
    assign wdata_unused = ^wdata;
    assign frm_fer = frm_res.fer;
    assign frm_per = frm_res.per;

    rx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxs)
    );

    rx_frame #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .tick    (baud_tick),
        .rxs     (rxs),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (frm_done),
        .res     (frm_res)
    );

    rx_regs #(
        .DATA_W (DATA_W)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (frm_done),
        .res   (frm_res),
        .addr  (addr),
        .rd    (rd),
        .wr    (wr),
        .rdata (rdata),
        .full  (buf_full),
        .flags (stat_flags)
    );

endmodule

// File: rtl/uart_rx_stat_chk.sv
// Module: uart_rx_stat_chk
// Property checker for the serial receiver, bound to the top module.
module uart_rx_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       rd,
    input logic       wr,
    input logic [7:0] rdata,
    input logic       frm_done,
    input logic       frm_fer,
    input logic       frm_per,
    input logic       full,
    input logic [2:0] flags
);

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1) |-> (rdata[7:3] == 5'd0));

    p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1 && !frm_done) |=> (flags == 3'b000));

    p_fer_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> (flags[0] == $past(frm_fer)));

    p_per_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> (flags[2] == $past(frm_per)));

    p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && full) |=> flags[1]);

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> full);

    p_read_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd0 && !frm_done) |=> !full);

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr && addr == 2'd1)) |=> flags[1]);

    p_frame_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_fer && wr && addr == 2'd1) |=> flags[0]);

endmodule

bind uart_rx_stat uart_rx_stat_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd       (rd),
    .wr       (wr),
    .rdata    (rdata),
    .frm_done (frm_done),
    .frm_fer  (frm_fer),
    .frm_per  (frm_per),
    .full     (buf_full),
    .flags    (stat_flags)
);

// File: tb/test_uart_rx_stat.sv
// Directed bench for uart_rx_stat: one task per scenario.
module test_uart_rx_stat;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    uart_rx_stat i_uart_rx_stat (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .addr(addr),
        .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    // 16x tick: one clock high every TICK_DIV clocks
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            baud_tick = (c == TICK_DIV - 1);
            c = (c + 1) % TICK_DIV;
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] d);
        @(negedge clk);
        addr = 2'd1; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic hold_bit(input logic lvl);
        rxd = lvl;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Frame: start, 8 data LSB first, optional parity, stop; then idle
    task automatic send(input logic [7:0] d, input bit use_par, input logic pbit,
                        input logic stop_lvl);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (use_par) hold_bit(pbit);
        hold_bit(stop_lvl);
        hold_bit(1'b1);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd1, v); chk("R1 status after reset", v, 8'h00);
    endtask

    task automatic t_basic;
        logic [7:0] v;
        send(8'hA5, 0, 0, 1); rd_reg(2'd0, v); chk("R2 byte A5", v, 8'hA5);
        rd_reg(2'd1, v); chk("R7 clean status", v, 8'h00);
        send(8'h3C, 0, 0, 1); rd_reg(2'd0, v); chk("R2 byte 3C", v, 8'h3C);
    endtask

    task automatic t_stop_err;
        logic [7:0] v;
        send(8'h55, 0, 0, 0); rd_reg(2'd1, v); chk("R5 R3 bad stop", v, 8'h01);
        rd_reg(2'd0, v);
        send(8'h12, 0, 0, 1); rd_reg(2'd1, v); chk("R7 framing recomputed", v, 8'h00);
        rd_reg(2'd0, v);
    endtask

    task automatic t_start_err;
        logic [7:0] v;
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (11 * BIT_CLKS) @(negedge clk);
        rd_reg(2'd1, v); chk("R6 short start status", v, 8'h01);
        rd_reg(2'd0, v); chk("R6 short start data", v, 8'hFF);
        wr_stat(8'h00);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h07, 1, 1'b1, 1); rd_reg(2'd1, v); chk("R8 even ok", v, 8'h00);
        rd_reg(2'd0, v);
        send(8'h07, 1, 1'b0, 1); rd_reg(2'd1, v); chk("R8 R3 even bad", v, 8'h04);
        rd_reg(2'd0, v); chk("R8 data with parity", v, 8'h07);
        par_odd = 1'b1;
        send(8'h07, 1, 1'b0, 1); rd_reg(2'd1, v); chk("R8 odd ok clears", v, 8'h00);
        rd_reg(2'd0, v);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        wr_stat(8'h00);
        send(8'h11, 0, 0, 1);
        send(8'h22, 0, 0, 1);
        rd_reg(2'd1, v); chk("R9 R3 overrun", v, 8'h02);
        rd_reg(2'd0, v); chk("R9 overwrite", v, 8'h22);
        send(8'h33, 0, 0, 1);
        rd_reg(2'd1, v); chk("R11 overrun sticky", v, 8'h02);
        wr_stat(8'hFF);
        rd_reg(2'd1, v); chk("R4 write clears", v, 8'h00);
        rd_reg(2'd0, v);
    endtask

    task automatic t_read_empties;
        logic [7:0] v;
        send(8'h44, 0, 0, 1); rd_reg(2'd0, v);
        send(8'h45, 0, 0, 1);
        rd_reg(2'd1, v); chk("R10 no overrun after read", v, 8'h00);
        rd_reg(2'd0, v); chk("R10 second byte", v, 8'h45);
    endtask

    task automatic t_disable;
        logic [7:0] v;
        wr_stat(8'h00);
        send(8'h66, 0, 0, 1);
        rx_en = 1'b0;
        send(8'h77, 0, 0, 0);
        rd_reg(2'd1, v); chk("R12 disabled no flags", v, 8'h00);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h88, 0, 0, 1);
        rd_reg(2'd1, v); chk("R12 overrun after reenable", v, 8'h02);
        rd_reg(2'd0, v); chk("R12 new byte", v, 8'h88);
        wr_stat(8'h5A);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        addr = 2'd1; wr = 1'b1;
        fork
            send(8'h9C, 0, 0, 0);
            begin
                repeat (11 * BIT_CLKS) begin
                    @(negedge clk);
                    #1 if (rdata[0]) seen = 1'b1;
                end
            end
        join
        wr = 1'b0;
        chk("R13 frame beats write", {7'd0, seen}, 8'h01);
        rd_reg(2'd0, v);
        wr_stat(8'h00);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_basic;
        t_stop_err;
        t_start_err;
        t_parity;
        t_overrun;
        t_read_empties;
        t_disable;
        t_priority;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule